// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Tick Generator

This block produces the bit timing for an asynchronous serial controller. It advances only on cycles where the bus clock enable is high. That enable marks the bus clock, which is the oscillator frequency divided by four. An 8-bit rate register, written over a simple write strobe, selects the rate in two stages:

- a prescaler with a ratio of 1, 3, 4 or 13;
- a binary stage that divides further by a power of two, from 1 to 128.

The block drives two outputs:

- a 16x oversampling tick;
- a per-bit tick, raised on every sixteenth oversampling tick.

A synchronous reset loads the rate register. If the bootstrap input is high during reset, the register starts at the slow bootstrap rate; otherwise it starts at the fastest rate. Any write to the rate register restarts the timing from zero. The first tick after a write therefore arrives one full new period later.

Top module: `baud_tick_gen`

## Requirements
- R1: The rate register reads back, on `rate_rd`, exactly the last 8-bit value written. A write takes effect at the clock edge of the cycle in which `wr_en` is high.
- R2: Bits 5:4 of the rate register select the prescale ratio P: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R3: Bits 2:0 hold a value S. `tick16` is high for one clock after every P·2^S counted enable cycles. This makes one bit P·16·2^S bus cycles long.
- R4: `tick_bit` is high together with every sixteenth `tick16` pulse, and at no other time.
- R5: Only clock cycles with `bus_en` high are counted. Cycles with `bus_en` low do not advance the timing.
- R6: Reset with `boot_sel` low clears the rate register to 0x00. This gives a `tick16` after every enable cycle and 16 bus cycles per bit.
- R7: Reset with `boot_sel` high loads 0x33 (P=13, S=3). This gives 1664 bus cycles per bit.
- R8: A write clears both counter stages and the per-bit count. Both ticks are low in the cycle after the write. An enable in the write cycle is not counted. The first `tick16` comes after P·2^S further enable cycles.
- R9: Bits 7, 6 and 3 of the rate register are stored but do not change the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel | input | 1 | Bootstrap mode select, sampled during reset |
| bus_en | input | 1 | Bus clock enable (oscillator divided by four) |
| wr_en | input | 1 | Rate register write strobe |
| wr_data | input | 8 | Rate register write value |
| rate_rd | output | 8 | Rate register read value |
| tick16 | output | 1 | 16x oversampling tick |
| tick_bit | output | 1 | Per-bit tick |

## Verification
The bench covers every prescale code and every power-of-two select. A design that mixed up the ratio encoding, or shifted the select by one, would tick at the wrong period and be flagged on the first cycle that differs. The enable is made irregular, so a design that counted raw clocks would tick too early. Writes land mid-period and in cycles with the enable high, so a design that did not reload its counters, or counted the write cycle, would tick early or late. The reset default and the bootstrap rate are checked over a full bit, and rates written with the don't-care bits set are compared against the same rates written with them clear.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int RW  = 8,
  parameter int SW  = 3,
  parameter int OVS = 16,
  parameter logic [7:0] BOOT_RATE = 8'h33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_sel,
  input  logic          bus_en,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  output logic [RW-1:0] rate_rd,
  output logic          tick16,
  output logic          tick_bit
);
  localparam int PCW = (1 << SW) - 1;
  localparam int OW  = $clog2(OVS);
  localparam int PRE_LO = 4;

  logic [RW-1:0]  rate_q;
  logic [3:0]     pre_cnt, pre_last;
  logic [PCW-1:0] pow_cnt, pow_last;
  logic [OW-1:0]  ovs_cnt;
  logic           t16_q, tb_q;

  always_comb begin
    case (rate_q[PRE_LO+1:PRE_LO])
      2'b00:   pre_last = 4'd0;
      2'b01:   pre_last = 4'd2;
      2'b10:   pre_last = 4'd3;
      default: pre_last = 4'd12;
    endcase
  end

  assign pow_last = (PCW'(1) << rate_q[SW-1:0]) - PCW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= boot_sel ? RW'(BOOT_RATE) : '0;
      pre_cnt <= '0;
      pow_cnt <= '0;
      ovs_cnt <= '0;
      t16_q   <= 1'b0;
      tb_q    <= 1'b0;
    end else if (wr_en) begin
      rate_q  <= wr_data;
      pre_cnt <= '0;
      pow_cnt <= '0;
      ovs_cnt <= '0;
      t16_q   <= 1'b0;
      tb_q    <= 1'b0;
    end else begin
      t16_q <= 1'b0;
      tb_q  <= 1'b0;
      if (bus_en) begin
        if (pre_cnt == pre_last) begin
          pre_cnt <= '0;
          if (pow_cnt == pow_last) begin
            pow_cnt <= '0;
            t16_q   <= 1'b1;
            if (ovs_cnt == OW'(OVS - 1)) begin
              ovs_cnt <= '0;
              tb_q    <= 1'b1;
            end else begin
              ovs_cnt <= ovs_cnt + OW'(1);
            end
          end else begin
            pow_cnt <= pow_cnt + PCW'(1);
          end
        end else begin
          pre_cnt <= pre_cnt + 4'd1;
        end
      end
    end
  end

  assign rate_rd  = rate_q;
  assign tick16   = t16_q;
  assign tick_bit = tb_q;

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> rate_rd == $past(wr_data)); // R1
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last); // R2
  AST_POW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pow_cnt <= pow_last); // R3
  AST_BIT_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_bit |-> tick16); // R4
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && $past(rst_n)) |-> $past(bus_en)); // R5
  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> rate_rd == ($past(boot_sel) ? RW'(BOOT_RATE) : RW'(0))); // R6
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (!tick16 && !tick_bit)); // R8
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0, boot_sel = 1'b0, bus_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rate_rd;
  logic tick16, tick_bit;

  always #4 clk = ~clk;

  baud_tick_gen dut (.clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .bus_en(bus_en),
    .wr_en(wr_en), .wr_data(wr_data), .rate_rd(rate_rd), .tick16(tick16), .tick_bit(tick_bit));

  int vectors = 0, fails = 0;
  bit done = 0;
  string tag = "R6";
  int en_mode = 0;

  int m_rate = 0, m_cnt = 0, m_ticks = 0;
  bit m_t16 = 0, m_tb = 0;

  function automatic int period(int r);
    int p;
    case ((r >> 4) & 3)
      0: p = 1;
      1: p = 3;
      2: p = 4;
      default: p = 13;
    endcase
    return p * (1 << (r & 7));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate = boot_sel ? 8'h33 : 8'h00;
      m_cnt = 0; m_ticks = 0; m_t16 = 0; m_tb = 0;
    end else if (wr_en) begin
      m_rate = int'(wr_data);
      m_cnt = 0; m_ticks = 0; m_t16 = 0; m_tb = 0;
    end else begin
      m_t16 = 0; m_tb = 0;
      if (bus_en) begin
        m_cnt++;
        if (m_cnt == period(m_rate)) begin
          m_cnt = 0;
          m_t16 = 1;
          m_ticks++;
          if (m_ticks == 16) begin
            m_ticks = 0;
            m_tb = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (rate_rd !== m_rate[7:0] || tick16 !== m_t16 || tick_bit !== m_tb) begin
        fails++;
        $display("FAIL %s: rate=%h tick16=%b tick_bit=%b expected rate=%h tick16=%b tick_bit=%b",
                 tag, rate_rd, tick16, tick_bit, m_rate[7:0], m_t16, m_tb);
      end
      case (en_mode)
        0: bus_en = 1'b1;
        1: bus_en = ($urandom % 4) != 0;
        default: bus_en = ($urandom % 2) != 0;
      endcase
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(logic [7:0] v);
    @(negedge clk);
    wr_data = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(logic boot);
    @(negedge clk);
    boot_sel = boot;
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
  endtask

  initial begin
    tag = "R6"; en_mode = 0;
    do_reset(1'b0);
    run(60);
    tag = "R7";
    do_reset(1'b1);
    run(1664 * 16 + 200);
    do_reset(1'b0);
    tag = "R1";
    for (int v = 0; v < 256; v++) write(8'(v));
    tag = "R2";
    for (int p = 0; p < 4; p++) begin
      write(8'((p << 4) | 1));
      run(period((p << 4) | 1) * 16 * 2 + 20);
    end
    tag = "R3";
    for (int s = 0; s < 8; s++) begin
      write(8'(8'h10 | s));
      run(period(8'h10 | s) * 16 + 40);
    end
    tag = "R4";
    write(8'h20);
    run(4 * 16 * 4 + 10);
    tag = "R5";
    en_mode = 1;
    write(8'h11);
    run(1200);
    en_mode = 2;
    write(8'h32);
    run(2000);
    en_mode = 0;
    tag = "R8";
    for (int k = 0; k < 20; k++) begin
      write(8'h01);
      run(k % 3);
      write(8'h12);
      run(5 + k);
    end
    write(8'h00);
    write(8'h00);
    run(40);
    tag = "R9";
    write(8'hC9);
    run(16 * 2 * 3 + 20);
    write(8'hFA);
    run(13 * 4 * 16 + 20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog (%s): run did not end, actual=hung expected=finished", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule